// File: doc/BRIEF.md
# Nibble-Bus Data RAM Bank

This block is one bank of nibble-wide data memory that hangs on a shared 4-bit bus. The processor keeps all memory traffic on that bus. Each instruction cycle begins on a rising edge of the sync line and runs through eight phases, one phase per clock: three address phases (A1 to A3), two opcode phases (M1, M2) and three execute phases (X1 to X3). The bank watches the opcode nibbles in M1 and M2 and classifies the instruction. It acts in the execute phases only when its own bank-select line is high.

A select instruction sends an 8-bit address as two nibbles: the high nibble in X2 and the low nibble in X3. The bank keeps that address until the next select that reaches it. Later access instructions move one nibble in X2 between the bus and the addressed cell. The cells are grouped as four chips of four sections, and each section holds twenty characters. Sixteen of them are main characters, reached through the address. The other four are status characters, reached by index from the opcode.

The bus is split into an input, an output and an output-enable. The bank asserts the enable only in the X2 phase of a read. An external tri-state buffer or multiplexer joins the three onto the shared wires.

Top module: `nibble_ram_bank`

## Requirements
- R1: Reset (synchronous, active high) sets the held address to 0x00 and holds `bus_oe` low. Memory contents are not cleared, so a read right after reset returns the cell at address 0x00.
- R2: A low-to-high change of `sync` sampled on a clock edge makes that cycle A1. The following cycles are A2, A3, M1, M2, X1, X2 and X3, one per clock. After X3 the bank idles until the next rising edge of `sync`.
- R3: The opcode is the bus nibble in M1 (high part, `opr`) and the bus nibble in M2 (low part, `opa`). The bank decodes it as follows:
  - select: `opr`=0x2 with `opa` odd.
  - main write: `opr`=0xE, `opa`=0x0.
  - main read: `opr`=0xE, `opa`=0x9.
  - status write: `opr`=0xE, `opa`=0x4 to 0x7.
  - status read: `opr`=0xE, `opa`=0xC to 0xF.
  - every other code: no operation.
- R4: On a select with `bank_sel` high in X2, the bank takes the X2 nibble as address bits [7:4] and the X3 nibble as bits [3:0]. The new address applies from the next instruction on.
- R5: A select with `bank_sel` low in X2 leaves the held address unchanged.
- R6: A main write with `bank_sel` high stores the X2 bus nibble in a cell chosen by the held address: chip = bits [7:6], section = bits [5:4], character = bits [3:0]. Different addresses reach separate cells.
- R7: A read with `bank_sel` high drives the addressed nibble on `bus_out` with `bus_oe` high, in the X2 phase only. `bus_oe` is low in every other phase.
- R8: A write or read with `bank_sel` low in X2 stores nothing and does not raise `bus_oe`.
- R9: The held address persists across any number of access instructions and non-select instructions.
- R10: Status writes and reads use chip and section from the held address and status character `opa[1:0]`. These four cells per section are separate from the sixteen main characters.
- R11: An instruction decoded as no operation changes neither memory nor the held address, and it does not raise `bus_oe`.
- R12: If `sync` stays high past A1, the current cycle runs normally. No new instruction cycle starts until `sync` has been low and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one instruction phase per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sync | input | 1 | Instruction-cycle start marker; a rising edge marks A1 |
| bank_sel | input | 1 | Bank-select line for this bank, active high |
| bus_in | input | 4 | Nibble currently on the shared bus |
| bus_out | output | 4 | Nibble the bank drives during a read |
| bus_oe | output | 1 | High while the bank drives the bus |

## Verification
A wrong phase count appears in the first read: `bus_oe` rises in the wrong cycle, or it does not rise at all. A corrupt held address does not show when it is captured. It shows at the next read, where the nibble returned belongs to a different cell. For this reason every select in the bench is followed by a read that tells the old address from the new one. A write that lands in the wrong cell, or a status access that hits a main character, shows when a later read returns a stale nibble.

// File: rtl/nibble_ram_pkg.sv
package nibble_ram_pkg;

    localparam int NIB_W      = 4;
    localparam int CHIPS      = 4;
    localparam int SECTIONS   = 4;
    localparam int MAIN_CHARS = 16;
    localparam int STAT_CHARS = 4;
    localparam int CHARS      = MAIN_CHARS + STAT_CHARS;
    localparam int DEPTH      = CHIPS * SECTIONS * CHARS;
    localparam int IDX_W      = $clog2(DEPTH);
    localparam int CHIP_W     = $clog2(CHIPS);
    localparam int SECT_W     = $clog2(SECTIONS);
    localparam int CHAR_W     = $clog2(MAIN_CHARS);
    localparam int STAT_W     = $clog2(STAT_CHARS);
    localparam int SECT_SPAN  = CHARS;
    localparam int CHIP_SPAN  = SECTIONS * CHARS;

    typedef enum logic [3:0] {
        PH_IDLE, PH_A1, PH_A2, PH_A3, PH_M1, PH_M2, PH_X1, PH_X2, PH_X3
    } phase_e;

    typedef enum logic [2:0] {
        OP_NONE, OP_SELECT, OP_WR_MAIN, OP_RD_MAIN, OP_WR_STAT, OP_RD_STAT
    } op_e;

    typedef struct packed {
        logic [CHIP_W-1:0] chip;
        logic [SECT_W-1:0] sect;
        logic [CHAR_W-1:0] chr;
    } addr_t;

    function automatic phase_e phase_after(input phase_e p);
        case (p)
            PH_A1:   return PH_A2;
            PH_A2:   return PH_A3;
            PH_A3:   return PH_M1;
            PH_M1:   return PH_M2;
            PH_M2:   return PH_X1;
            PH_X1:   return PH_X2;
            PH_X2:   return PH_X3;
            default: return PH_IDLE;
        endcase
    endfunction

    function automatic op_e classify(input logic [NIB_W-1:0] opr,
                                     input logic [NIB_W-1:0] opa);
        if (opr == 4'h2 && opa[0])                  return OP_SELECT;
        if (opr == 4'hE) begin
            if (opa == 4'h0)                        return OP_WR_MAIN;
            if (opa == 4'h9)                        return OP_RD_MAIN;
            if (opa[3:2] == 2'b01)                  return OP_WR_STAT;
            if (opa[3:2] == 2'b11)                  return OP_RD_STAT;
        end
        return OP_NONE;
    endfunction

endpackage

// File: rtl/phase_seq.sv
module phase_seq
    import nibble_ram_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sync,
    output phase_e phase_now
);
    logic   sync_prev;
    phase_e ph_q;
    logic   start;

    assign start = sync && !sync_prev;

    always_comb begin
        if (start) phase_now = PH_A1;
        else       phase_now = phase_after(ph_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_prev <= 1'b1;
            ph_q      <= PH_IDLE;
        end else begin
            sync_prev <= sync;
            ph_q      <= phase_now;
        end
    end

    // R2: the opcode phases follow each other unless a new cycle starts
    assert_phase_walk_R2: assert property (@(posedge clk) disable iff (rst)
        (phase_now == PH_M1) |=> (phase_now == PH_M2 || phase_now == PH_A1));

    // R12: a sync line held high does not restart the cycle
    assert_no_restart_R12: assert property (@(posedge clk) disable iff (rst)
        (sync && phase_now == PH_X3) |=> (phase_now == PH_IDLE));

endmodule

// File: rtl/op_capture.sv
module op_capture
    import nibble_ram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase_now,
    input  logic [NIB_W-1:0]  bus_in,
    output op_e               op_cls,
    output logic [STAT_W-1:0] stat_idx
);
    logic [NIB_W-1:0] opr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            opr_q    <= '0;
            op_cls   <= OP_NONE;
            stat_idx <= '0;
        end else begin
            case (phase_now)
                PH_A1: op_cls <= OP_NONE;
                PH_M1: opr_q  <= bus_in;
                PH_M2: begin
                    op_cls   <= classify(opr_q, bus_in);
                    stat_idx <= bus_in[STAT_W-1:0];
                end
                default: ;
            endcase
        end
    end

    // R3: a decoded class is only ever formed from the M2 nibble
    assert_class_at_m2_R3: assert property (@(posedge clk) disable iff (rst)
        (op_cls != OP_NONE && $past(op_cls) == OP_NONE && !$past(rst))
            |-> $past(phase_now) == PH_M2);

endmodule

// File: rtl/addr_hold.sv
module addr_hold
    import nibble_ram_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  phase_e           phase_now,
    input  op_e              op_cls,
    input  logic             bank_sel,
    input  logic [NIB_W-1:0] bus_in,
    output addr_t            addr_q
);
    logic [NIB_W-1:0] hi_q;
    logic             pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= '0;
            pend_q <= 1'b0;
            addr_q <= '0;
        end else begin
            if (phase_now == PH_X2) begin
                pend_q <= (op_cls == OP_SELECT) && bank_sel;
                hi_q   <= bus_in;
            end else if (phase_now == PH_X3) begin
                if (pend_q) addr_q <= addr_t'({hi_q, bus_in});
                pend_q <= 1'b0;
            end else begin
                pend_q <= 1'b0;
            end
        end
    end

    // R1: reset leaves the address at zero
    assert_reset_addr_R1: assert property (@(posedge clk)
        rst |=> (addr_q == '0));

    // R9: the address moves only at the end of an X3 phase
    assert_addr_commit_R9: assert property (@(posedge clk) disable iff (rst)
        (!$stable(addr_q) && !$past(rst)) |-> ($past(phase_now) == PH_X3));

endmodule

// File: rtl/nib_store.sv
module nib_store
    import nibble_ram_pkg::*;
(
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [NIB_W-1:0] wdata,
    output logic [NIB_W-1:0] rdata
);
    logic [NIB_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/nibble_ram_bank.sv
module nibble_ram_bank
    import nibble_ram_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sync,
    input  logic             bank_sel,
    input  logic [NIB_W-1:0] bus_in,
    output logic [NIB_W-1:0] bus_out,
    output logic             bus_oe
);
    phase_e            phase_now;
    op_e               op_cls;
    logic [STAT_W-1:0] stat_idx;
    addr_t             addr_q;
    logic [IDX_W-1:0]  idx;
    logic [NIB_W-1:0]  rdata;
    logic              act;
    logic              is_stat;
    logic              we;
    int                char_sel;

    phase_seq u_phase (
        .clk       (clk),
        .rst       (rst),
        .sync      (sync),
        .phase_now (phase_now)
    );

    op_capture u_op (
        .clk       (clk),
        .rst       (rst),
        .phase_now (phase_now),
        .bus_in    (bus_in),
        .op_cls    (op_cls),
        .stat_idx  (stat_idx)
    );

    addr_hold u_addr (
        .clk       (clk),
        .rst       (rst),
        .phase_now (phase_now),
        .op_cls    (op_cls),
        .bank_sel  (bank_sel),
        .bus_in    (bus_in),
        .addr_q    (addr_q)
    );

    always_comb begin
        is_stat  = (op_cls == OP_WR_STAT) || (op_cls == OP_RD_STAT);
        char_sel = is_stat ? (MAIN_CHARS + int'(stat_idx)) : int'(addr_q.chr);
        idx      = IDX_W'(int'(addr_q.chip) * CHIP_SPAN
                        + int'(addr_q.sect) * SECT_SPAN + char_sel);
        act      = (phase_now == PH_X2) && bank_sel;
        we       = act && ((op_cls == OP_WR_MAIN) || (op_cls == OP_WR_STAT));
        bus_oe   = act && ((op_cls == OP_RD_MAIN) || (op_cls == OP_RD_STAT));
        bus_out  = bus_oe ? rdata : '0;
    end

    nib_store u_store (
        .clk   (clk),
        .we    (we),
        .idx   (idx),
        .wdata (bus_in),
        .rdata (rdata)
    );

    // R1: no drive right after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !bus_oe);

    // R7: the drive window is a single phase
    assert_single_drive_R7: assert property (@(posedge clk) disable iff (rst)
        bus_oe |=> !bus_oe);

    // R8: neither drive nor store without the bank line
    assert_drive_needs_sel_R8: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> bank_sel);
    assert_store_needs_sel_R8: assert property (@(posedge clk) disable iff (rst)
        we |-> bank_sel);

endmodule

// File: tb/tb_nibble_ram_bank.sv
module tb_nibble_ram_bank;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync = 1'b0;
    logic       bank_sel = 1'b0;
    logic [3:0] bus_in = 4'h0;
    logic [3:0] bus_out;
    logic       bus_oe;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    nibble_ram_bank dut (
        .clk      (clk),
        .rst      (rst),
        .sync     (sync),
        .bank_sel (bank_sel),
        .bus_in   (bus_in),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe)
    );

    typedef struct packed {
        logic [3:0] req;
        logic [3:0] opr;
        logic [3:0] opa;
        logic [3:0] x2;
        logic [3:0] x3;
        logic       sel;
        logic       exp_oe;
        logic [3:0] exp_d;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        '{4'd1,  4'hE, 4'h0, 4'h5, 4'h0, 1'b1, 1'b0, 4'h0}, // R1 write at reset address
        '{4'd1,  4'hE, 4'h9, 4'h0, 4'h0, 1'b1, 1'b1, 4'h5}, // R1 read back
        '{4'd4,  4'h2, 4'h1, 4'hA, 4'h7, 1'b1, 1'b0, 4'h0}, // R4 select A7
        '{4'd6,  4'hE, 4'h0, 4'hC, 4'h0, 1'b1, 1'b0, 4'h0}, // R6 write C
        '{4'd6,  4'hE, 4'h9, 4'h0, 4'h0, 1'b1, 1'b1, 4'hC}, // R6 read C
        '{4'd4,  4'h2, 4'h3, 4'h0, 4'h0, 1'b1, 1'b0, 4'h0}, // R4 select 00
        '{4'd4,  4'hE, 4'h9, 4'h0, 4'h0, 1'b1, 1'b1, 4'h5}, // R4 old cell again
        '{4'd9,  4'hE, 4'h9, 4'h0, 4'h0, 1'b1, 1'b1, 4'h5}, // R9 address kept
        '{4'd5,  4'h2, 4'h1, 4'hA, 4'h7, 1'b0, 1'b0, 4'h0}, // R5 unselected select
        '{4'd5,  4'hE, 4'h9, 4'h0, 4'h0, 1'b1, 1'b1, 4'h5}, // R5 still 00
        '{4'd8,  4'hE, 4'h0, 4'h9, 4'h0, 1'b0, 1'b0, 4'h0}, // R8 unselected write
        '{4'd8,  4'hE, 4'h9, 4'h0, 4'h0, 1'b1, 1'b1, 4'h5}, // R8 cell untouched
        '{4'd8,  4'hE, 4'h9, 4'h0, 4'h0, 1'b0, 1'b0, 4'h0}, // R8 unselected read
        '{4'd11, 4'h2, 4'h0, 4'hA, 4'h7, 1'b1, 1'b0, 4'h0}, // R11 even opa: no select
        '{4'd11, 4'hE, 4'h9, 4'h0, 4'h0, 1'b1, 1'b1, 4'h5}, // R11 address unchanged
        '{4'd11, 4'hE, 4'h8, 4'hF, 4'h0, 1'b1, 1'b0, 4'h0}, // R11 undefined code
        '{4'd11, 4'hE, 4'h9, 4'h0, 4'h0, 1'b1, 1'b1, 4'h5}, // R11 memory unchanged
        '{4'd10, 4'hE, 4'h5, 4'h3, 4'h0, 1'b1, 1'b0, 4'h0}, // R10 status write idx1
        '{4'd10, 4'hE, 4'hD, 4'h0, 4'h0, 1'b1, 1'b1, 4'h3}, // R10 status read idx1
        '{4'd10, 4'hE, 4'h9, 4'h0, 4'h0, 1'b1, 1'b1, 4'h5}, // R10 main cell separate
        '{4'd4,  4'h2, 4'h1, 4'hA, 4'h7, 1'b1, 1'b0, 4'h0}, // R4 select A7 again
        '{4'd9,  4'hE, 4'h9, 4'h0, 4'h0, 1'b1, 1'b1, 4'hC}, // R9 earlier write kept
        '{4'd3,  4'h2, 4'hF, 4'hF, 4'hF, 1'b1, 1'b0, 4'h0}, // R3 select with opa F
        '{4'd3,  4'hE, 4'h0, 4'hE, 4'h0, 1'b1, 1'b0, 4'h0}, // R3 write E at FF
        '{4'd3,  4'hE, 4'h9, 4'h0, 4'h0, 1'b1, 1'b1, 4'hE}, // R3 read E
        '{4'd6,  4'h2, 4'h1, 4'hB, 4'h7, 1'b1, 1'b0, 4'h0}, // R6 other section
        '{4'd6,  4'hE, 4'h0, 4'h6, 4'h0, 1'b1, 1'b0, 4'h0}, // R6 write 6
        '{4'd6,  4'h2, 4'h1, 4'hA, 4'h7, 1'b1, 1'b0, 4'h0}, // R6 back to A7
        '{4'd6,  4'hE, 4'h9, 4'h0, 4'h0, 1'b1, 1'b1, 4'hC}, // R6 A7 kept C
        '{4'd6,  4'h2, 4'h1, 4'hB, 4'h7, 1'b1, 1'b0, 4'h0}, // R6 to B7
        '{4'd6,  4'hE, 4'h9, 4'h0, 4'h0, 1'b1, 1'b1, 4'h6}, // R6 B7 holds 6
        '{4'd4,  4'h2, 4'h1, 4'h0, 4'h0, 1'b1, 1'b0, 4'h0}  // R4 park at 00
    };

    task automatic check(input int req, input string what,
                         input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    // one instruction cycle, eight phases; X2 is phase index 6
    task automatic run_instr(input logic [3:0] opr, input logic [3:0] opa,
                             input logic [3:0] x2, input logic [3:0] x3,
                             input logic sel, input logic hold,
                             output logic oe_x2, output logic [3:0] d_x2,
                             output logic oe_other);
        oe_other = 1'b0;
        oe_x2    = 1'b0;
        d_x2     = 4'h0;
        for (int ph = 0; ph < 8; ph++) begin
            @(posedge clk); #1;
            sync     = (ph == 0) || hold;
            bank_sel = sel;
            case (ph)
                3:       bus_in = opr;
                4:       bus_in = opa;
                6:       bus_in = x2;
                7:       bus_in = x3;
                default: bus_in = 4'h0;
            endcase
            @(negedge clk);
            if (ph == 6) begin
                oe_x2 = bus_oe;
                d_x2  = bus_out;
            end else begin
                oe_other = oe_other | bus_oe;
            end
        end
    endtask

    task automatic idle_cycle();
        @(posedge clk); #1;
        sync = 1'b0; bus_in = 4'h0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic       oe, oo;
        logic [3:0] d;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(1, "bus_oe after reset", {3'b0, bus_oe}, 4'h0); // R1

        for (int i = 0; i < NV; i++) begin
            run_instr(VEC[i].opr, VEC[i].opa, VEC[i].x2, VEC[i].x3,
                      VEC[i].sel, 1'b0, oe, d, oo);
            check(int'(VEC[i].req), $sformatf("vec %0d oe in X2", i),
                  {3'b0, oe}, {3'b0, VEC[i].exp_oe});
            check(7, $sformatf("vec %0d oe outside X2", i), {3'b0, oo}, 4'h0); // R7
            if (VEC[i].exp_oe)
                check(int'(VEC[i].req), $sformatf("vec %0d data", i), d, VEC[i].exp_d);
        end

        // R12: sync kept high; the running cycle completes, no second start
        run_instr(4'hE, 4'h9, 4'h0, 4'h0, 1'b1, 1'b1, oe, d, oo);
        check(12, "held sync first read oe", {3'b0, oe}, 4'h1);
        check(12, "held sync first read data", d, 4'h5);
        run_instr(4'hE, 4'h9, 4'h0, 4'h0, 1'b1, 1'b1, oe, d, oo);
        check(12, "held sync no restart", {3'b0, oe | oo}, 4'h0);
        idle_cycle();
        // R2: a fresh rising edge starts a normal cycle again
        run_instr(4'hE, 4'h9, 4'h0, 4'h0, 1'b1, 1'b0, oe, d, oo);
        check(2, "restart after sync low", {3'b0, oe}, 4'h1);
        check(2, "restart data", d, 4'h5);

        // R1: reset mid-stream returns the address to 0x00, memory kept
        run_instr(4'h2, 4'h1, 4'hA, 4'h7, 1'b1, 1'b0, oe, d, oo);
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0; sync = 1'b0;
        @(negedge clk);
        check(1, "bus_oe after second reset", {3'b0, bus_oe}, 4'h0);
        idle_cycle();
        run_instr(4'hE, 4'h9, 4'h0, 4'h0, 1'b1, 1'b0, oe, d, oo);
        check(1, "read after reset oe", {3'b0, oe}, 4'h1);
        check(1, "read after reset at 00", d, 4'h5);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule